// File: doc/BRIEF.md
# DRAM Access Sequencer

This block turns single-word requests from a simple bus master into RAS/CAS strobe sequences for an external DRAM. The master presents an address and holds `req` high until it sees a one-cycle `done` pulse. The top three address bits select one of eight areas. Areas 2 to 5 behave as DRAM when their bit in `dram_map` is set. Every other access completes without touching the strobes.

An 8-bit control register chooses the behaviour at run time:
- bit 7 (`pre2`) sets the precharge length: one or two states.
- bit 6 (`burst`) selects fast page mode, in which RAS stays low and only CAS cycles for further accesses to the open row.
- bit 5 (`hold_ras`) decides whether an open row stays active (RAS held low) or closes when no request follows a completed access.
- bits 4:0 are spare storage that is read back but has no effect on sequencing.

A separate `wait_en` input decides whether the active-low `wait_n` pin can stretch the CAS-low phase.

The row address is the field `addr[ROW_W+COL_W-1:COL_W]`. The column address is `addr[COL_W-1:0]`. Both are driven on `mem_addr`, zero-extended to its width.

Top module: `dram_seq`

## Requirements
- R1: The control register is written from `reg_wdata` when `reg_we` is high, and all 8 bits read back on `reg_rdata` after the next edge. Synchronous `rst` clears it to 0x00. Out of reset, `ras_n` and `cas_n` are 1, `done` is 0 and `mem_addr` is 0.
- R2: A DRAM access from idle runs the following states in order, each shown on the cycle after the previous:
  - row address with RAS and CAS high;
  - row address with RAS low;
  - column address with CAS still high;
  - CAS low with the column address.
  The row state appears on the cycle after `req` is sampled in idle.
- R3: After RAS rises at the end of a row, it stays high for one precharge state when bit 7 is 0 and two when bit 7 is 1. One idle state follows before any new row state.
- R4: With bit 6 at 0, every DRAM access closes its row. `done` coincides with the first precharge state, and the next access repeats the full row sequence.
- R5: With bit 6 at 1, a DRAM access ends with RAS held low and the row left open. If the next request targets the same row in a DRAM area, it produces only a column state and CAS-low state(s), with RAS low throughout.
- R6: When a row is open, a request to a different row or to a non-DRAM area first negates RAS and runs the full precharge and idle states before serving the request.
- R7: When a row is open and no request is present in the cycle after `done`, bit 5 at 1 keeps RAS low until the next request. Bit 5 at 0 negates RAS and precharges.
- R8: With `wait_en` at 1, each CAS-low cycle in which `wait_n` is sampled 0 adds one more CAS-low cycle.
- R9: With `wait_en` at 0, `wait_n` has no effect: CAS stays low for exactly one cycle.
- R10: `done` is a single-cycle pulse on the cycle after the last CAS-low cycle. In that same cycle, `rd_data` holds the `mem_rdata` value sampled at the end of that last CAS-low cycle.
- R11: An access is treated as DRAM only when the area `addr[ROW_W+COL_W+2:ROW_W+COL_W]` is in 2..5 and `dram_map[area-2]` is 1. Any other access raises `done` on the cycle after it is accepted, with RAS and CAS high.
- R12: Writing any value to control bits 4:0 changes no strobe, address or `done` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on / hardware standby) |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| wait_en | input | 1 | Enables wait-state insertion from `wait_n` |
| dram_map | input | 4 | Bit i marks area i+2 as DRAM |
| req | input | 1 | Access request, held until `done` |
| addr | input | ROW_W+COL_W+3 | Area, row and column address |
| done | output | 1 | Access complete pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mem_rdata | input | DATA_W | Data returned by the DRAM |
| wait_n | input | 1 | External wait request, active low |

## Verification
The hardest state to reach is an open row under RAS-down mode that then meets a request it cannot serve in page mode: a different row, or a non-DRAM area. The stimulus gets there by enabling bursting and RAS hold, completing one access and leaving an idle gap so the row stays open. It then issues a miss and compares each following cycle against a queue of expected strobe states built from the register settings. Wait stretching is combined with a page hit under the two-state precharge setting, so the wait path runs both after a fresh row and inside an open row.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int AREA_W    = 3;
  localparam int AREA_BASE = 2;
  localparam int AREA_CNT  = 4;
  localparam int CTL_W     = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACT,
    ST_COL,
    ST_CASL,
    ST_OPEN,
    ST_PRE1,
    ST_PRE2,
    ST_NDONE
  } seq_state_e;

  typedef struct packed {
    logic       pre2;
    logic       burst;
    logic       hold_ras;
    logic [4:0] spare;
  } ctl_t;

endpackage

// File: rtl/dram_seq_ctl_reg.sv
module dram_seq_ctl_reg
  import dram_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);

  logic [CTL_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end

  assign ctl   = ctl_t'(q);
  assign rdata = q;

  // R1: synchronous reset empties the register
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/dram_seq_addr.sv
module dram_seq_addr
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AREA_W+ROW_W+COL_W-1:0] addr,
  input  logic [AREA_CNT-1:0]           dram_map,
  input  logic                          load,
  input  logic                          sel_col,
  output logic                          is_dram,
  output logic                          row_hit,
  output logic [MUX_W-1:0]              mem_addr
);

  localparam int ROW_LSB = COL_W;
  localparam int AREA_LSB = ROW_W + COL_W;

  logic [AREA_W-1:0]   area;
  logic [ROW_W-1:0]    in_row, lat_row, row_nx;
  logic [COL_W-1:0]    in_col, lat_col, col_nx;
  logic [AREA_CNT-1:0] area_hit;

  assign area   = addr[AREA_LSB +: AREA_W];
  assign in_row = addr[ROW_LSB +: ROW_W];
  assign in_col = addr[COL_W-1:0];

  for (genvar g = 0; g < AREA_CNT; g++) begin : g_area
    assign area_hit[g] = (area == AREA_W'(AREA_BASE + g)) & dram_map[g];
  end

  assign is_dram = |area_hit;
  assign row_hit = (in_row == lat_row);
  assign row_nx  = load ? in_row : lat_row;
  assign col_nx  = load ? in_col : lat_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_row  <= '0;
      lat_col  <= '0;
      mem_addr <= '0;
    end else begin
      lat_row  <= row_nx;
      lat_col  <= col_nx;
      mem_addr <= sel_col ? MUX_W'(col_nx) : MUX_W'(row_nx);
    end
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_dram,
  input  logic              row_hit,
  input  logic              pre2,
  input  logic              burst,
  input  logic              hold_ras,
  input  logic              wait_en,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load,
  output logic              sel_col,
  output logic              ras_n,
  output logic              cas_n,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  seq_state_e st_q, st_d;
  logic stretch, fin, page_ok;

  assign stretch = wait_en & ~wait_n;
  assign fin     = (st_q == ST_CASL) & ~stretch;
  assign page_ok = is_dram & row_hit & burst;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    case (st_q)
      ST_IDLE: if (req) begin
        load = 1'b1;
        st_d = is_dram ? ST_ROW : ST_NDONE;
      end
      ST_ROW:  st_d = ST_ACT;
      ST_ACT:  st_d = ST_COL;
      ST_COL:  st_d = ST_CASL;
      ST_CASL: if (!stretch) st_d = burst ? ST_OPEN : ST_PRE1;
      ST_OPEN: begin
        if (req) begin
          if (page_ok) begin
            load = 1'b1;
            st_d = ST_COL;
          end else begin
            st_d = ST_PRE1;
          end
        end else if (!(hold_ras && burst)) begin
          st_d = ST_PRE1;
        end
      end
      ST_PRE1: st_d = pre2 ? ST_PRE2 : ST_IDLE;
      ST_PRE2: st_d = ST_IDLE;
      ST_NDONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign sel_col = (st_d == ST_COL) || (st_d == ST_CASL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      st_q  <= st_d;
      ras_n <= !((st_d == ST_ACT) || (st_d == ST_COL) ||
                 (st_d == ST_CASL) || (st_d == ST_OPEN));
      cas_n <= (st_d != ST_CASL);
      done  <= fin || (st_d == ST_NDONE);
      if (fin) rd_data <= mem_rdata;
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: CAS only ever falls inside an active row
  a_r2_cas_under_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
  // R3: once RAS rises it stays high for precharge plus idle at least
  a_r3_ras_high_min: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n ##1 ras_n);
  // R8: a sampled wait keeps CAS low one more cycle
  a_r8_wait_stretch: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && wait_en && !wait_n) |=> !cas_n);
  // R9: with waits disabled CAS low lasts one cycle
  a_r9_wait_ignored: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && !wait_en) |=> cas_n);
  // R7: RAS-down mode keeps the row active while no request arrives
  a_r7_ras_down_holds: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cas_n && !req && hold_ras && burst) |=> !ras_n);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16,
  parameter int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_we,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  input  logic                          wait_en,
  input  logic [3:0]                    dram_map,
  input  logic                          req,
  input  logic [ROW_W+COL_W+2:0]        addr,
  output logic                          done,
  output logic [DATA_W-1:0]             rd_data,
  output logic [MUX_W-1:0]              mem_addr,
  output logic                          ras_n,
  output logic                          cas_n,
  input  logic [DATA_W-1:0]             mem_rdata,
  input  logic                          wait_n
);

  ctl_t ctl;
  logic load, sel_col, is_dram, row_hit;

  dram_seq_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .ctl   (ctl),
    .rdata (reg_rdata)
  );

  dram_seq_addr #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .dram_map (dram_map),
    .load     (load),
    .sel_col  (sel_col),
    .is_dram  (is_dram),
    .row_hit  (row_hit),
    .mem_addr (mem_addr)
  );

  dram_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .is_dram   (is_dram),
    .row_hit   (row_hit),
    .pre2      (ctl.pre2),
    .burst     (ctl.burst),
    .hold_ras  (ctl.hold_ras),
    .wait_en   (wait_en),
    .wait_n    (wait_n),
    .mem_rdata (mem_rdata),
    .load      (load),
    .sel_col   (sel_col),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .done      (done),
    .rd_data   (rd_data)
  );

  // R2: row address settles before RAS falls
  a_r2_row_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(mem_addr));
  // R2: column address settles before CAS falls
  a_r2_col_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $stable(mem_addr));

endmodule

// File: tb/dram_seq_tb_top.sv
`timescale 1ns/1ps
module dram_seq_tb_top;

  typedef struct packed {
    logic        ras;
    logic        cas;
    logic [5:0]  a;
    logic        d;
    logic        wn;
    logic [15:0] md;
    logic        chk;
    logic [15:0] rd;
    logic [7:0]  tag;
  } elem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        wait_en = 1'b0;
  logic [3:0]  dram_map = 4'b1011;
  logic        req = 1'b0;
  logic [14:0] addr = '0;
  logic        done;
  logic [15:0] rd_data;
  logic [5:0]  mem_addr;
  logic        ras_n, cas_n;
  logic [15:0] mem_rdata = 16'hDEAD;
  logic        wait_n = 1'b1;

  always #5 clk = ~clk;

  dram_seq #(.ROW_W(6), .COL_W(6), .DATA_W(16)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wait_en(wait_en), .dram_map(dram_map),
    .req(req), .addr(addr), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n),
    .mem_rdata(mem_rdata), .wait_n(wait_n)
  );

  int    total = 0;
  int    bad = 0;
  elem_t q[$];
  logic  m_open = 1'b0;
  logic [5:0] m_open_row = '0;
  logic [5:0] m_lat_row = '0;
  logic  c_pre2 = 1'b0, c_burst = 1'b0, c_hold = 1'b0;
  logic  last_done = 1'b0;

  function automatic elem_t mk(input logic r, input logic c, input logic [5:0] a,
                               input logic d, input logic [7:0] tag);
    mk = '{ras:r, cas:c, a:a, d:d, wn:1'b1, md:16'hDEAD, chk:1'b0, rd:16'h0, tag:tag};
  endfunction

  function automatic logic [14:0] mka(input int area, input int row, input int col);
    mka = {area[2:0], row[5:0], col[5:0]};
  endfunction

  task automatic check(input bit ok, input int tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: compare the model's expected strobes, then drive the next inputs
  task automatic cyc();
    elem_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = mk(!m_open, 1'b1, m_lat_row, 1'b0, m_open ? 8'd7 : 8'd2);
    check({ras_n, cas_n, done, mem_addr} == {e.ras, e.cas, e.d, e.a}, e.tag,
          "ras/cas/done/addr", {ras_n, cas_n, done, mem_addr}, {e.ras, e.cas, e.d, e.a});
    if (e.d && e.chk)
      check(rd_data == e.rd, 10, "rd_data", rd_data, e.rd);  // R10
    wait_n    = e.wn;
    mem_rdata = e.md;
    last_done = e.d;
  endtask

  task automatic push_close(input logic [7:0] tag);
    q.push_back(mk(1'b1, 1'b1, m_lat_row, 1'b0, tag));
    if (c_pre2) q.push_back(mk(1'b1, 1'b1, m_lat_row, 1'b0, tag));
    q.push_back(mk(1'b1, 1'b1, m_lat_row, 1'b0, tag));
  endtask

  task automatic access(input logic [14:0] a, input int nw, input logic [7:0] tag);
    logic [5:0] row, col;
    logic [15:0] pat;
    logic dram, hit;
    int area, n;
    elem_t e;
    row  = a[11:6];
    col  = a[5:0];
    area = int'(a[14:12]);
    dram = (area >= 2 && area <= 5) ? dram_map[area-2] : 1'b0;   // R11
    pat  = {1'b1, a};
    hit  = m_open && dram && c_burst && (row == m_open_row);
    if (m_open && !hit) begin
      push_close(8'd6);   // R6: full precharge before a new row
      m_open = 1'b0;
    end
    if (hit) begin
      q.push_back(mk(1'b0, 1'b1, col, 1'b0, 8'd5));   // R5
    end else if (!dram) begin
      m_lat_row = row;
      q.push_back(mk(1'b1, 1'b1, row, 1'b1, 8'd11));
      q.push_back(mk(1'b1, 1'b1, row, 1'b0, 8'd11));
    end else begin
      m_lat_row = row;
      q.push_back(mk(1'b1, 1'b1, row, 1'b0, tag));    // R2 row setup
      q.push_back(mk(1'b0, 1'b1, row, 1'b0, tag));
      q.push_back(mk(1'b0, 1'b1, col, 1'b0, tag));
    end
    if (dram) begin
      n = wait_en ? nw + 1 : 1;
      for (int i = 0; i < n; i++) begin
        e = mk(1'b0, 1'b0, col, 1'b0, tag);
        if (wait_en) e.wn = (i == n - 1);       // R8
        else         e.wn = (nw > 0) ? 1'b0 : 1'b1;  // R9
        e.md = (i == n - 1) ? pat : 16'hDEAD;
        q.push_back(e);
      end
      if (c_burst) begin
        e = mk(1'b0, 1'b1, row, 1'b1, 8'd10);
        e.chk = 1'b1; e.rd = pat;
        q.push_back(e);
        m_open = 1'b1;
        m_open_row = row;
      end else begin
        e = mk(1'b1, 1'b1, row, 1'b1, 8'd10);
        e.chk = 1'b1; e.rd = pat;
        q.push_back(e);
        if (c_pre2) q.push_back(mk(1'b1, 1'b1, row, 1'b0, 8'd3));  // R3
        q.push_back(mk(1'b1, 1'b1, row, 1'b0, 8'd3));
      end
    end
    addr = a;
    req  = 1'b1;
    do cyc(); while (!last_done);
    req = 1'b0;
  endtask

  task automatic gap(input int n);
    if (m_open && !(c_hold && c_burst)) begin
      push_close(8'd7);   // R7: RAS up mode closes the row
      m_open = 1'b0;
    end
    repeat (n) cyc();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    reg_we = 1'b1;
    reg_wdata = v;
    cyc();
    reg_we = 1'b0;
    check(reg_rdata == v, 1, "reg_rdata", reg_rdata, v);   // R1
    c_pre2 = v[7]; c_burst = v[6]; c_hold = v[5];
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete();
    m_open = 1'b0; m_lat_row = '0;
    c_pre2 = 1'b0; c_burst = 1'b0; c_hold = 1'b0;
    // R1: reset state at the ports
    check({ras_n, cas_n, done, mem_addr} == 9'b110_000000, 1, "reset strobes",
          {ras_n, cas_n, done, mem_addr}, 9'b110_000000);
    check(reg_rdata == 8'h00, 1, "reset reg", reg_rdata, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=no_done expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    wr_ctl(8'hFF);
    do_reset();                                   // R1 clears all bits

    // R2 R4: full accesses, single precharge (R3)
    wr_ctl(8'h00);
    access(mka(2, 5, 3), 0, 8'd2);
    access(mka(2, 9, 7), 0, 8'd4);
    access(mka(3, 9, 8), 0, 8'd4);
    gap(3);

    // R3: two precharge states
    wr_ctl(8'h80);
    access(mka(3, 17, 1), 0, 8'd3);
    access(mka(5, 40, 2), 0, 8'd3);
    gap(3);

    // R12: spare bits have no effect on sequencing
    wr_ctl(8'h1F);
    access(mka(2, 33, 63), 0, 8'd12);
    access(mka(2, 34, 0), 0, 8'd12);
    gap(3);

    // R8: waits enabled
    wait_en = 1'b1;
    wr_ctl(8'h00);
    access(mka(2, 12, 4), 2, 8'd8);
    access(mka(3, 13, 5), 1, 8'd8);
    gap(2);
    // R9: waits disabled, pin held low
    wait_en = 1'b0;
    access(mka(5, 14, 6), 3, 8'd9);
    gap(2);

    // R5 with R7 RAS up mode
    wr_ctl(8'h40);
    access(mka(2, 20, 1), 0, 8'd5);
    access(mka(2, 20, 2), 0, 8'd5);
    access(mka(2, 20, 3), 0, 8'd5);
    gap(4);

    // R7 RAS down mode, R6 misses, R11 area decode
    wr_ctl(8'h60);
    access(mka(3, 21, 9), 0, 8'd5);
    gap(3);
    access(mka(3, 21, 10), 0, 8'd5);
    access(mka(3, 22, 11), 0, 8'd6);
    access(mka(4, 22, 12), 0, 8'd11);
    gap(2);
    access(mka(6, 1, 1), 0, 8'd11);
    access(mka(0, 2, 2), 0, 8'd11);
    access(mka(5, 23, 13), 0, 8'd5);
    gap(2);
    access(mka(7, 3, 3), 0, 8'd11);
    gap(2);

    // R6 with two precharge states, R8 inside an open row
    wait_en = 1'b1;
    wr_ctl(8'hE0);
    access(mka(5, 30, 1), 0, 8'd2);
    access(mka(5, 31, 2), 0, 8'd6);
    access(mka(5, 31, 3), 1, 8'd8);
    gap(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule